// File: doc/BRIEF.md
# Serial Bit Timing Recovery with Gated Data Clock

This block sits behind an FSK demodulator and turns its raw serial bit stream into something a plain shift register or a small controller can consume. Words arrive asynchronously at a nominal 1200 bit/s, each framed as one low start bit, eight data bits (first bit received first) and one high stop bit. The block watches the line for a falling edge, confirms it half a bit later, and then locates the centre of every following bit from a baud tick running at sixteen ticks per bit. The tick is divided down from the system clock by a parameter.

The line itself is passed straight through to the data output. Alongside it the block drives a gated clock that produces exactly one rising edge per data bit, at the bit centre, and stays low across the start and stop bits. A shift register clocked by it therefore captures only the payload. An active-low word-done pulse marks each complete frame. Two gating inputs decide whether any of this happens. The carrier-valid input, when low, quietens the outputs and abandons any frame in progress. The power-down input holds the outputs high.

Top module: `fsk_bit_timing`

## Requirements
- R1: While idle, a high-to-low change of `serIn` begins a frame. The first posedge of `clk` at which `serIn` is low after being high is the frame's reference edge; a baud tick occurs every `TICK_DIV` clocks after it, sixteen per bit.
- R2: A frame with a low start bit produces exactly eight rising edges on `bitClk`, one per data bit, and none for the start or stop bit.
- R3: The rising edge of `bitClk` for data bit j (j = 0..7) follows the clock edge that lies 8 + 16·(j+1) ticks after the reference edge, which is the nominal centre of that bit.
- R4: Each `bitClk` pulse stays high for 8 ticks, half a bit time.
- R5: When the stop bit is high at its centre, 152 ticks after the reference edge, `wordDoneN` goes low for 8 ticks and then returns high. There is one such pulse per frame.
- R6: A stop bit that is low at its centre gives no `wordDoneN` pulse, although the eight data clocks are still issued.
- R7: If `serIn` is high again when resampled 8 ticks after the reference edge, the edge is taken as a glitch and the block returns to idle with no `bitClk` or `wordDoneN` activity.
- R8: While `carrierOk` is low and `powerDown` is low, `dataOut` is high, `bitClk` is low and `wordDoneN` is high. Any frame in progress is abandoned.
- R9: While `powerDown` is high, `dataOut`, `bitClk` and `wordDoneN` are all high and any frame in progress is abandoned.
- R10: While `carrierOk` is high and `powerDown` is low, `dataOut` follows `serIn`.
- R11: A start bit that begins immediately at the end of the previous stop bit is detected, so back-to-back frames are each recovered in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serIn | input | 1 | Raw demodulated serial line |
| carrierOk | input | 1 | High while a valid carrier is present |
| powerDown | input | 1 | High forces the power-down output state |
| dataOut | output | 1 | Pass-through data, forced high when gated |
| bitClk | output | 1 | Gated burst clock, one rising edge per data bit centre |
| wordDoneN | output | 1 | Active-low end-of-word pulse, half a bit long |

## Verification
The main function is exercised with every one of the 256 byte values in turn. Each value gives a different pattern of line transitions inside the frame, so a sampling point that drifts off centre or a miscounted bit shows up as a wrong captured byte, a wrong edge count or a shifted edge time. A frame with a low stop bit separates the data-clock path from the word-done path. Two low pulses on the line, one short and one a tick short of half a bit, separate glitch rejection from real start detection. Two frames sent with no idle time between them show whether the block is ready for a new start edge at the end of the stop bit. Carrier loss and power-down are each applied partway through a frame, which shows whether the frame is abandoned and whether the outputs take their forced levels.

// File: rtl/bit_timing_pkg.sv
package bit_timing_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  // Strobes from the timing control into the output datapath
  typedef struct packed {
    logic clkRise;   // data bit centre reached
    logic clkFall;   // half a bit after a centre
    logic wordEnd;   // valid stop bit seen at its centre
    logic flush;     // gating inputs inactive: clear everything
  } timingStrobe_t;

endpackage

// File: rtl/bit_timing_ctrl.sv
module bit_timing_ctrl
  import bit_timing_pkg::*;
#(
  parameter int TICK_DIV   = 2604,
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          serIn,
  input  logic          runEn,
  output timingStrobe_t strobe
);

  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam int PH_W  = $clog2(OVERSAMPLE);
  localparam int HALF  = OVERSAMPLE / 2;
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  rxState_t          state;
  logic              prevIn;
  logic [DIV_W-1:0]  divCnt;
  logic [PH_W-1:0]   phase;
  logic [IDX_W-1:0]  bitIdx;

  logic tick, fallEdge, halfPoint, bitEdge;

  assign tick      = (divCnt == DIV_W'(TICK_DIV - 1));
  assign fallEdge  = prevIn && !serIn;
  assign halfPoint = tick && (phase == PH_W'(HALF - 1));
  assign bitEdge   = tick && (phase == PH_W'(OVERSAMPLE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      prevIn <= 1'b1;
      divCnt <= '0;
      phase  <= '0;
      bitIdx <= '0;
    end else begin
      prevIn <= serIn;
      if (!runEn) begin
        state  <= ST_IDLE;
        divCnt <= '0;
        phase  <= '0;
        bitIdx <= '0;
      end else if (state == ST_IDLE) begin
        if (fallEdge) begin
          state  <= ST_START;
          divCnt <= '0;
          phase  <= '0;
        end
      end else begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick)
          phase <= (phase == PH_W'(OVERSAMPLE - 1)) ? '0 : phase + 1'b1;
        case (state)
          ST_START: if (halfPoint) begin
            phase  <= '0;             // realign on the start bit centre
            bitIdx <= '0;
            state  <= serIn ? ST_IDLE : ST_DATA;
          end
          ST_DATA: if (bitEdge) begin
            if (bitIdx == IDX_W'(DATA_BITS - 1)) state <= ST_STOP;
            else                                 bitIdx <= bitIdx + 1'b1;
          end
          ST_STOP: if (bitEdge) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe.clkRise = runEn && (state == ST_DATA) && bitEdge;
    strobe.clkFall = runEn && ((state == ST_DATA) || (state == ST_STOP)) && halfPoint;
    strobe.wordEnd = runEn && (state == ST_STOP) && bitEdge && serIn;
    strobe.flush   = !runEn;
  end

  // R7: a line that is high again at the half-bit resample is a glitch
  p_glitch_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && state == ST_START && halfPoint && serIn) |=> state == ST_IDLE);

  // R2: the stop state is reached only after the last data bit index
  p_burst_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP) |-> bitIdx == IDX_W'(DATA_BITS - 1));

endmodule

// File: rtl/bit_timing_path.sv
module bit_timing_path
  import bit_timing_pkg::*;
#(
  parameter int TICK_DIV   = 2604,
  parameter int OVERSAMPLE = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          serIn,
  input  logic          carrierOk,
  input  logic          powerDown,
  input  timingStrobe_t strobe,
  output logic          dataOut,
  output logic          bitClk,
  output logic          wordDoneN
);

  localparam int PULSE_CLKS = TICK_DIV * OVERSAMPLE / 2;
  localparam int CNT_W      = $clog2(PULSE_CLKS + 1);

  logic             bitClkReg;
  logic [CNT_W-1:0] pulseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitClkReg <= 1'b0;
      pulseCnt  <= '0;
    end else if (strobe.flush) begin
      bitClkReg <= 1'b0;
      pulseCnt  <= '0;
    end else begin
      if (strobe.clkRise)      bitClkReg <= 1'b1;
      else if (strobe.clkFall) bitClkReg <= 1'b0;

      if (strobe.wordEnd)      pulseCnt <= CNT_W'(PULSE_CLKS);
      else if (pulseCnt != '0) pulseCnt <= pulseCnt - 1'b1;
    end
  end

  always_comb begin
    dataOut   = (powerDown || !carrierOk) ? 1'b1 : serIn;
    bitClk    = powerDown ? 1'b1 : bitClkReg;
    wordDoneN = powerDown ? 1'b1 : (pulseCnt == '0);
  end

  // R9: power-down holds every output high
  p_pd_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> (dataOut && bitClk && wordDoneN));

  // R8: one cycle into carrier loss the outputs are quiet
  p_nocarrier_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!carrierOk && !powerDown) |=>
      (carrierOk || powerDown || (dataOut && !bitClk && wordDoneN)));

  // R4: the previous pulse has ended before the next bit centre
  p_rise_from_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clkRise |-> !bitClkReg);

  // R5: a word-done pulse has finished before the next one is started
  p_single_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wordEnd |-> (pulseCnt == '0));

endmodule

// File: rtl/fsk_bit_timing.sv
module fsk_bit_timing
  import bit_timing_pkg::*;
#(
  parameter int TICK_DIV   = 2604,
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic serIn,
  input  logic carrierOk,
  input  logic powerDown,
  output logic dataOut,
  output logic bitClk,
  output logic wordDoneN
);

  timingStrobe_t strobe;
  logic          runEn;

  assign runEn = carrierOk && !powerDown;

  bit_timing_ctrl #(
    .TICK_DIV  (TICK_DIV),
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_BITS (DATA_BITS)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .serIn (serIn),
    .runEn (runEn),
    .strobe(strobe)
  );

  bit_timing_path #(
    .TICK_DIV  (TICK_DIV),
    .OVERSAMPLE(OVERSAMPLE)
  ) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .serIn    (serIn),
    .carrierOk(carrierOk),
    .powerDown(powerDown),
    .strobe   (strobe),
    .dataOut  (dataOut),
    .bitClk   (bitClk),
    .wordDoneN(wordDoneN)
  );

endmodule

// File: tb/sim_fsk_bit_timing.sv
`timescale 1ns/1ps
module sim_fsk_bit_timing;

  localparam int D    = 2;        // clocks per baud tick
  localparam int BIT  = 16 * D;   // clocks per bit
  localparam int HALF = 8 * D;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b1;
  logic carrierOk = 1'b1;
  logic powerDown = 1'b0;
  logic dataOut, bitClk, wordDoneN;

  always #10 clk = ~clk;  // 50 MHz

  fsk_bit_timing #(.TICK_DIV(D), .OVERSAMPLE(16), .DATA_BITS(8)) u0 (
    .clk(clk), .rstN(rstN), .serIn(serIn), .carrierOk(carrierOk),
    .powerDown(powerDown), .dataOut(dataOut), .bitClk(bitClk),
    .wordDoneN(wordDoneN)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFails  = 0;

  // port monitor, sampled on the falling clock edge
  int riseCnt = 0, doneCnt = 0, doneCyc = 0, doneWidth = 0;
  int riseStart = 0, widthBad = 0;
  int riseCyc [0:15];
  logic [7:0] capByte = '0;
  logic prevClk = 1'b0, prevDone = 1'b1;

  always @(negedge clk) begin
    if (bitClk && !prevClk) begin
      if (riseCnt < 16) riseCyc[riseCnt] = cyc;
      riseStart = cyc;
      capByte   = {dataOut, capByte[7:1]};
      riseCnt   = riseCnt + 1;
    end
    if (!bitClk && prevClk && (cyc - riseStart != HALF)) widthBad = widthBad + 1;
    if (!wordDoneN && prevDone) begin
      doneCnt = doneCnt + 1;
      doneCyc = cyc;
    end
    if (wordDoneN && !prevDone) doneWidth = cyc - doneCyc;
    prevClk  = bitClk;
    prevDone = wordDoneN;
  end

  task automatic clearMon();
    riseCnt = 0; doneCnt = 0; doneCyc = 0; doneWidth = 0;
    widthBad = 0; capByte = '0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // called on a falling clock edge; c0 is the cycle count when the start bit is driven
  task automatic sendFrame(input logic [7:0] b, input logic stopV, output int c0);
    c0 = cyc;
    serIn = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int j = 0; j < 8; j++) begin
      serIn = b[j];
      repeat (BIT) @(negedge clk);
    end
    serIn = stopV;
    repeat (BIT) @(negedge clk);
    serIn = 1'b1;
  endtask

  function automatic int centreCyc(input int c0, input int j);
    return c0 + 1 + HALF + BIT * (j + 1);
  endfunction

  initial begin
    int c0, c1;
    repeat (3) @(negedge clk);
    chk(dataOut == 1'b1,   "R10 reset dataOut", dataOut, 1);
    chk(bitClk == 1'b0,    "R2 reset bitClk", bitClk, 0);
    chk(wordDoneN == 1'b1, "R5 reset wordDoneN", wordDoneN, 1);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // sweep every byte value: R1 R2 R3 R4 R5 R10
    for (int v = 0; v < 256; v++) begin
      clearMon();
      sendFrame(8'(v), 1'b1, c0);
      repeat (4) @(negedge clk);
      chk(capByte == 8'(v), "R10 captured byte", capByte, v);
      chk(riseCnt == 8,     "R2 rises per word", riseCnt, 8);
      chk(riseCyc[0] == centreCyc(c0, 0), "R3 first centre", riseCyc[0], centreCyc(c0, 0));
      chk(riseCyc[7] == centreCyc(c0, 7), "R3 last centre",  riseCyc[7], centreCyc(c0, 7));
      chk(widthBad == 0,    "R4 pulse width", widthBad, 0);
      chk(doneCnt == 1,     "R5 done count", doneCnt, 1);
      chk(doneCyc == centreCyc(c0, 8), "R5 done at stop centre", doneCyc, centreCyc(c0, 8));
      chk(doneWidth == HALF, "R5 done width", doneWidth, HALF);
    end
    chk(riseCyc[3] - riseCyc[2] == BIT, "R1 tick spacing", riseCyc[3] - riseCyc[2], BIT);

    // missing stop bit
    clearMon();
    sendFrame(8'hA5, 1'b0, c0);
    repeat (20) @(negedge clk);
    chk(riseCnt == 8, "R6 clocks still issued", riseCnt, 8);
    chk(doneCnt == 0, "R6 no done pulse", doneCnt, 0);

    // glitches: short, and one tick short of half a bit
    clearMon();
    serIn = 1'b0; repeat (3 * D) @(negedge clk); serIn = 1'b1;
    repeat (400) @(negedge clk);
    serIn = 1'b0; repeat (7 * D) @(negedge clk); serIn = 1'b1;
    repeat (400) @(negedge clk);
    chk(riseCnt == 0, "R7 glitch no clocks", riseCnt, 0);
    chk(doneCnt == 0, "R7 glitch no done", doneCnt, 0);

    // back-to-back frames
    clearMon();
    sendFrame(8'h3C, 1'b1, c0);
    sendFrame(8'hC3, 1'b1, c1);
    repeat (4) @(negedge clk);
    chk(riseCnt == 16, "R11 rises two frames", riseCnt, 16);
    chk(doneCnt == 2,  "R11 done two frames", doneCnt, 2);
    chk(riseCyc[8] == centreCyc(c1, 0), "R11 second frame timing", riseCyc[8], centreCyc(c1, 0));
    chk(capByte == 8'hC3, "R11 second byte", capByte, 8'hC3);

    // carrier loss mid-frame, dropped while a clock pulse is high
    clearMon();
    fork
      sendFrame(8'h00, 1'b1, c0);
      begin
        repeat (50) @(negedge clk);
        chk(dataOut == serIn, "R10 pass-through", dataOut, serIn);
        repeat (40) @(negedge clk);
        carrierOk = 1'b0;
        repeat (2) @(negedge clk);
        chk(dataOut == 1'b1,   "R8 dataOut high", dataOut, 1);
        chk(bitClk == 1'b0,    "R8 bitClk low", bitClk, 0);
        chk(wordDoneN == 1'b1, "R8 wordDoneN high", wordDoneN, 1);
      end
    join
    repeat (4) @(negedge clk);
    carrierOk = 1'b1;
    repeat (400) @(negedge clk);
    chk(riseCnt == 2, "R8 frame abandoned rises", riseCnt, 2);
    chk(doneCnt == 0, "R8 frame abandoned done", doneCnt, 0);

    // power-down mid-frame
    clearMon();
    fork
      sendFrame(8'h00, 1'b1, c0);
      begin
        repeat (90) @(negedge clk);
        powerDown = 1'b1;
        repeat (2) @(negedge clk);
        chk(dataOut == 1'b1,   "R9 dataOut high", dataOut, 1);
        chk(bitClk == 1'b1,    "R9 bitClk high", bitClk, 1);
        chk(wordDoneN == 1'b1, "R9 wordDoneN high", wordDoneN, 1);
      end
    join
    repeat (4) @(negedge clk);
    powerDown = 1'b0;
    repeat (400) @(negedge clk);
    chk(bitClk == 1'b0, "R9 bitClk after wake", bitClk, 0);
    chk(doneCnt == 0,   "R9 frame abandoned", doneCnt, 0);
    clearMon();
    sendFrame(8'h5A, 1'b1, c0);
    repeat (4) @(negedge clk);
    chk(capByte == 8'h5A, "R9 receive after wake", capByte, 8'h5A);
    chk(riseCnt == 8,     "R9 rises after wake", riseCnt, 8);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog (all) act=timeout exp=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule